// File: doc/BRIEF.md
# Prescaled PWM Timer with Held Update

This block generates one pulse-width-modulated output. A divider built from a power-of-two prescaler slows the input clock to a tick. The tick steps a 10-bit count. The count restarts after a programmed number of ticks, the period. The output is high for the first part of each period, the phase, and low for the rest.

Software sets the block through two 32-bit registers on a simple write bus. A read is combinational and depends only on the address. The control word holds the enable, a hold bit, a spare storage bit and the division exponent N, which is split across two fields. The count word holds the period and the phase. Each register holds the programmed values. A separate active set drives the waveform.

Programmed values move to the active set in three cases:
- at the end of a period;
- at once while the channel is idle;
- never while the hold bit is set.

Several fields can therefore be changed and released together, which avoids a shortened or glitched pulse. An exponent above 24 is treated as 24.

The sequencer has two states:
- `ST_IDLE`: the output is low and the counters are cleared.
- `ST_RUN`: the waveform is generated.

Transitions:
- start, `ST_IDLE`→`ST_RUN`: the enable is set, the active period and phase are both non-zero, and no released update is still waiting.
- stop, `ST_RUN`→`ST_IDLE`: the enable is cleared, or the active period or phase is zero.

Top module: `pwm_sync_timer`

## Requirements
- R1: After reset both registers read 0 and `pwm_out` is low.
- R2: Address 0x0 is the control word. Its writable bits are 0 (enable), 4 (spare), 11 (hold), 15 (exponent bit 0) and 19:16 (exponent bits 4:1). Address 0x4 is the count word: period in bits 25:16 and phase in bits 9:0. All other bits read 0. Reads return the programmed values.
- R3: Each count step lasts 2^N input clocks, where N = {ctrl[19:16], ctrl[15]}.
- R4: While running, the output repeats with a period of period×2^N clocks. It is high for the first phase×2^N clocks of each period and low otherwise.
- R5: When the phase is greater than or equal to the period, the output stays high continuously.
- R6: With the enable set and a zero period or zero phase, the output stays low. The channel starts once legal values are written.
- R7: Clearing the enable drives the output low from the clock edge that takes the write. Re-enabling starts a fresh period that begins with the high phase.
- R8: While the hold bit is 1, writes to the period, phase and exponent do not change the output. When the hold bit returns to 0 they take effect together.
- R9: A count or exponent change written while running lets the current period finish with the old values. The new values start at the next period boundary.
- R10: Bit 4 of the control word is stored and read back but does not affect the output.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Input clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_addr | input | 3 | Byte address: 0x0 control, 0x4 count |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr` (combinational) |
| pwm_out | output | 1 | Pulse-width-modulated output |

## Verification
The assertions check four rules on every cycle:
- the count moves only on a prescaler tick and stays below the active period;
- the active set never changes while the hold bit has been set for at least one cycle;
- a change of the active set during a run coincides with the count restarting at zero;
- a cleared enable always leads to the idle state.

Only the bench scenarios can show the visible waveform. These cover the high and low lengths for several exponents, the all-high case, the refusal to start on zero values, the exact cycle at which a mid-period update lands, and readback of the held fields.

// File: rtl/pwmt_pkg.sv
package pwmt_pkg;

    localparam int DATA_W    = 32;

    // register offsets (byte addresses)
    localparam int CTL_OFS   = 0;
    localparam int CNT_OFS   = 4;

    // control word bit positions
    localparam int EN_BIT    = 0;
    localparam int SPARE_BIT = 4;
    localparam int HOLD_BIT  = 11;
    localparam int XLSB_BIT  = 15;
    localparam int XHI_LSB   = 16;

    // count word field positions
    localparam int PER_LSB   = 16;
    localparam int PH_LSB    = 0;

    typedef enum logic [0:0] {
        ST_IDLE = 1'b0,
        ST_RUN  = 1'b1
    } run_state_t;

endpackage

// File: rtl/pwmt_regs.sv
module pwmt_regs
    import pwmt_pkg::*;
#(
    parameter int ADDR_W  = 3,
    parameter int CNT_W   = 10,
    parameter int EXP_W   = 5,
    parameter int EXP_MAX = 24
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata,
    input  logic              can_load,
    output logic              en,
    output logic              hold,
    output logic              upd_pend,
    output logic [CNT_W-1:0]  act_per,
    output logic [CNT_W-1:0]  act_ph,
    output logic [EXP_W-1:0]  act_exp
);

    localparam int XHI_W = EXP_W - 1;

    logic             wr_ctl;
    logic             wr_cnt;
    logic             pend;
    logic             do_load;
    logic             sh_spare;
    logic             sh_xlsb;
    logic [XHI_W-1:0] sh_xhi;
    logic [CNT_W-1:0] sh_per;
    logic [CNT_W-1:0] sh_ph;
    logic [EXP_W-1:0] sh_exp;
    logic             unused_wdata;

    assign wr_ctl       = wr && (addr == ADDR_W'(CTL_OFS));
    assign wr_cnt       = wr && (addr == ADDR_W'(CNT_OFS));
    assign sh_exp       = {sh_xhi, sh_xlsb};
    assign upd_pend     = pend && !hold;
    assign do_load      = upd_pend && can_load;
    assign unused_wdata = ^wdata;

    // programmed (shadow) control fields
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            en       <= 1'b0;
            sh_spare <= 1'b0;
            hold     <= 1'b0;
            sh_xlsb  <= 1'b0;
            sh_xhi   <= '0;
        end else if (wr_ctl) begin
            en       <= wdata[EN_BIT];
            sh_spare <= wdata[SPARE_BIT];
            hold     <= wdata[HOLD_BIT];
            sh_xlsb  <= wdata[XLSB_BIT];
            sh_xhi   <= wdata[XHI_LSB +: XHI_W];
        end
    end

    // programmed (shadow) count fields
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sh_per <= '0;
            sh_ph  <= '0;
        end else if (wr_cnt) begin
            sh_per <= wdata[PER_LSB +: CNT_W];
            sh_ph  <= wdata[PH_LSB +: CNT_W];
        end
    end

    // an update waits here until the hold bit is clear and the core allows it
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pend <= 1'b0;
        end else if ((wr_ctl && !wdata[HOLD_BIT]) || (wr_cnt && !hold)) begin
            pend <= 1'b1;
        end else if (do_load) begin
            pend <= 1'b0;
        end
    end

    // active set, copied as one unit
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            act_per <= '0;
            act_ph  <= '0;
            act_exp <= '0;
        end else if (do_load) begin
            act_per <= sh_per;
            act_ph  <= sh_ph;
            act_exp <= (sh_exp > EXP_W'(EXP_MAX)) ? EXP_W'(EXP_MAX) : sh_exp;
        end
    end

    always_comb begin
        rdata = '0;
        if (addr == ADDR_W'(CTL_OFS)) begin
            rdata[EN_BIT]              = en;
            rdata[SPARE_BIT]           = sh_spare;
            rdata[HOLD_BIT]            = hold;
            rdata[XLSB_BIT]            = sh_xlsb;
            rdata[XHI_LSB +: XHI_W]    = sh_xhi;
        end else if (addr == ADDR_W'(CNT_OFS)) begin
            rdata[PER_LSB +: CNT_W]    = sh_per;
            rdata[PH_LSB +: CNT_W]     = sh_ph;
        end
    end

endmodule

// File: rtl/pwmt_prescale.sv
module pwmt_prescale #(
    parameter int PRE_W = 24,
    parameter int EXP_W = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic [EXP_W-1:0] expo,
    output logic             tick
);

    logic [PRE_W-1:0] pre_q;
    logic [PRE_W-1:0] lim;

    // 2^expo - 1; an exponent equal to PRE_W yields all ones
    assign lim  = ~({PRE_W{1'b1}} << expo);
    assign tick = run && (pre_q == lim);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pre_q <= '0;
        end else if (!run || tick) begin
            pre_q <= '0;
        end else begin
            pre_q <= pre_q + PRE_W'(1);
        end
    end

endmodule

// File: rtl/pwmt_core.sv
module pwmt_core
    import pwmt_pkg::*;
#(
    parameter int CNT_W = 10
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic             upd_pend,
    input  logic             tick,
    input  logic [CNT_W-1:0] act_per,
    input  logic [CNT_W-1:0] act_ph,
    output logic             run,
    output logic [CNT_W-1:0] cnt,
    output logic             can_load,
    output logic             pwm_out
);

    run_state_t state_q;
    run_state_t state_d;
    logic       legal;
    logic       wrap;

    assign legal = (act_per != '0) && (act_ph != '0);
    assign wrap  = tick && (cnt == act_per - CNT_W'(1));

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (en && legal && !upd_pend) state_d = ST_RUN;   // start
            ST_RUN:  if (!en || !legal)            state_d = ST_IDLE;  // stop
            default: state_d = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // period counter
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (state_q != ST_RUN) begin
            cnt <= '0;
        end else if (wrap) begin
            cnt <= '0;
        end else if (tick) begin
            cnt <= cnt + CNT_W'(1);
        end
    end

    // outputs
    always_comb begin
        run      = (state_q == ST_RUN);
        can_load = (state_q == ST_IDLE) || wrap;
        pwm_out  = (state_q == ST_RUN) && en && legal && (cnt < act_ph);
    end

endmodule

// File: rtl/pwm_sync_timer.sv
module pwm_sync_timer #(
    parameter int ADDR_W  = 3,
    parameter int DATA_W  = 32,
    parameter int CNT_W   = 10,
    parameter int EXP_MAX = 24,
    parameter int EXP_W   = $clog2(EXP_MAX + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              pwm_out
);

    logic             core_run;
    logic             can_load;
    logic             tick;
    logic             en;
    logic             hold;
    logic             upd_pend;
    logic [CNT_W-1:0] core_cnt;
    logic [CNT_W-1:0] act_per;
    logic [CNT_W-1:0] act_ph;
    logic [EXP_W-1:0] act_exp;

    pwmt_regs #(
        .ADDR_W  (ADDR_W),
        .CNT_W   (CNT_W),
        .EXP_W   (EXP_W),
        .EXP_MAX (EXP_MAX)
    ) u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr       (bus_wr),
        .addr     (bus_addr),
        .wdata    (bus_wdata),
        .rdata    (bus_rdata),
        .can_load (can_load),
        .en       (en),
        .hold     (hold),
        .upd_pend (upd_pend),
        .act_per  (act_per),
        .act_ph   (act_ph),
        .act_exp  (act_exp)
    );

    pwmt_prescale #(
        .PRE_W (EXP_MAX),
        .EXP_W (EXP_W)
    ) u_pre (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (core_run),
        .expo  (act_exp),
        .tick  (tick)
    );

    pwmt_core #(
        .CNT_W (CNT_W)
    ) u_core (
        .clk      (clk),
        .rst_n    (rst_n),
        .en       (en),
        .upd_pend (upd_pend),
        .tick     (tick),
        .act_per  (act_per),
        .act_ph   (act_ph),
        .run      (core_run),
        .cnt      (core_cnt),
        .can_load (can_load),
        .pwm_out  (pwm_out)
    );

endmodule

// File: rtl/pwmt_checker.sv
module pwmt_checker #(
    parameter int CNT_W = 10,
    parameter int EXP_W = 5
) (
    input logic             clk,
    input logic             rst_n,
    input logic             en,
    input logic             hold,
    input logic             core_run,
    input logic             tick,
    input logic [CNT_W-1:0] core_cnt,
    input logic [CNT_W-1:0] act_per,
    input logic [CNT_W-1:0] act_ph,
    input logic [EXP_W-1:0] act_exp
);

    // R3: the count advances only on a prescaler tick
    a_r3_step_on_tick: assert property (@(posedge clk) disable iff (!rst_n)
        (core_run && $past(core_run) && !$stable(core_cnt)) |-> $past(tick));

    // R4: the count stays inside the active period
    a_r4_cnt_in_period: assert property (@(posedge clk) disable iff (!rst_n)
        (core_run && act_per != '0) |-> (core_cnt < act_per));

    // R8: a held update never reaches the active set
    a_r8_hold_freezes: assert property (@(posedge clk) disable iff (!rst_n)
        (hold && $past(hold)) |->
            ($stable(act_per) && $stable(act_ph) && $stable(act_exp)));

    // R9: while running, the active set changes only at a period restart
    a_r9_load_at_boundary: assert property (@(posedge clk) disable iff (!rst_n)
        (core_run && $past(core_run) &&
         !$stable({act_per, act_ph, act_exp})) |-> (core_cnt == '0));

    // R7: a cleared enable returns the sequencer to idle
    a_r7_disable_idles: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> !core_run);

endmodule

bind pwm_sync_timer pwmt_checker u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .en       (en),
    .hold     (hold),
    .core_run (core_run),
    .tick     (tick),
    .core_cnt (core_cnt),
    .act_per  (act_per),
    .act_ph   (act_ph),
    .act_exp  (act_exp)
);

// File: tb/sim_pwm_sync_timer.sv
`timescale 1ns/1ps
module sim_pwm_sync_timer;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_wr = 1'b0;
    logic [2:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        pwm_out;

    int n_chk = 0;
    int n_err = 0;

    always #2.5 clk = ~clk;

    pwm_sync_timer u0 (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_wr    (bus_wr),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .pwm_out   (pwm_out)
    );

    // {exponent, period, phase, spare bit}
    localparam int VEC [6][4] = '{
        '{0, 5, 2, 0},
        '{1, 4, 1, 1},
        '{2, 3, 2, 0},
        '{3, 2, 1, 1},
        '{0, 10, 9, 0},
        '{1, 7, 3, 1}
    };

    function automatic logic [31:0] ctl_word(input int en, input int hold,
                                             input int spare, input int n);
        logic [31:0] w;
        w        = '0;
        w[0]     = en[0];
        w[4]     = spare[0];
        w[11]    = hold[0];
        w[15]    = n[0];
        w[19:16] = n[4:1];
        return w;
    endfunction

    function automatic logic [31:0] cnt_word(input int per, input int ph);
        logic [31:0] w;
        w        = '0;
        w[25:16] = per[9:0];
        w[9:0]   = ph[9:0];
        return w;
    endfunction

    task automatic check(input string tag, input logic [31:0] act,
                         input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // called at a falling edge; returns at the falling edge after the write edge
    task automatic wr_reg(input logic [2:0] a, input logic [31:0] d);
        bus_wr    = 1'b1;
        bus_addr  = a;
        bus_wdata = d;
        @(posedge clk);
        @(negedge clk);
        bus_wr    = 1'b0;
    endtask

    task automatic rd_reg(input logic [2:0] a, output logic [31:0] v);
        bus_addr = a;
        #1;
        v = bus_rdata;
    endtask

    task automatic wait_rise(output bit found);
        logic prev;
        prev  = pwm_out;
        found = 1'b0;
        for (int i = 0; i < 4000 && !found; i++) begin
            @(negedge clk);
            if (!prev && pwm_out) found = 1'b1;
            prev = pwm_out;
        end
    endtask

    task automatic count_high(input int cycles, output int h);
        h = 0;
        for (int i = 0; i < cycles; i++) begin
            @(negedge clk);
            h += int'(pwm_out);
        end
    endtask

    // one full period starting at a rising edge, then the next rise
    task automatic measure(input string tag, input int per, input int ph,
                           input int n);
        bit   found;
        int   highs;
        logic last;
        logic nxt;
        wait_rise(found);
        check({tag, " rise seen"}, 32'(found), 32'd1);
        if (found) begin
            highs = 1;
            last  = 1'b1;
            for (int i = 1; i < (per << n); i++) begin
                @(negedge clk);
                highs += int'(pwm_out);
                last   = pwm_out;
            end
            @(negedge clk);
            nxt = pwm_out;
            check({tag, " high clocks"}, 32'(highs), 32'(ph << n));
            check({tag, " period end"}, {30'd0, last, nxt}, 32'b01);
        end
    endtask

    initial begin
        #500000;
        n_chk++;
        n_err++;
        $display("FAIL watchdog: run did not complete actual=hung expected=done");
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end

    initial begin
        logic [31:0] v;
        logic [7:0]  seq;
        int          h;
        bit          found;

        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: reset state
        rd_reg(3'h0, v);
        check("R1 control after reset", v, 32'h0);
        rd_reg(3'h4, v);
        check("R1 count after reset", v, 32'h0);
        check("R1 output after reset", 32'(pwm_out), 32'h0);

        // R2: register map and readback
        wr_reg(3'h0, 32'hFFFF_FFFE);
        rd_reg(3'h0, v);
        check("R2 control bits", v, 32'h000F_8810);
        wr_reg(3'h4, 32'hFFFF_FFFF);
        rd_reg(3'h4, v);
        check("R2 count fields", v, 32'h03FF_03FF);
        rd_reg(3'h2, v);
        check("R2 unmapped address", v, 32'h0);
        wr_reg(3'h0, 32'h0);

        // R3, R4, R10: vector table
        for (int i = 0; i < 6; i++) begin
            wr_reg(3'h0, 32'h0);
            wr_reg(3'h4, cnt_word(VEC[i][1], VEC[i][2]));
            wr_reg(3'h0, ctl_word(1, 0, VEC[i][3], VEC[i][0]));
            rd_reg(3'h0, v);
            check($sformatf("R10 vec%0d control readback", i), v,
                  ctl_word(1, 0, VEC[i][3], VEC[i][0]));
            measure($sformatf("R3/R4 vec%0d", i), VEC[i][1], VEC[i][2], VEC[i][0]);
        end

        // R5: phase not below period keeps output high
        wr_reg(3'h0, 32'h0);
        wr_reg(3'h4, cnt_word(4, 4));
        wr_reg(3'h0, ctl_word(1, 0, 0, 0));
        repeat (6) @(negedge clk);
        count_high(16, h);
        check("R5 phase equal period", 32'(h), 32'd16);
        wr_reg(3'h4, cnt_word(3, 9));
        repeat (8) @(negedge clk);
        count_high(16, h);
        check("R5 phase above period", 32'(h), 32'd16);

        // R6: zero values refuse to start
        wr_reg(3'h0, 32'h0);
        wr_reg(3'h4, cnt_word(0, 3));
        wr_reg(3'h0, ctl_word(1, 0, 0, 0));
        count_high(20, h);
        check("R6 zero period stays low", 32'(h), 32'd0);
        wr_reg(3'h4, cnt_word(4, 0));
        count_high(20, h);
        check("R6 zero phase stays low", 32'(h), 32'd0);
        wr_reg(3'h4, cnt_word(4, 1));
        measure("R6 start after legal values", 4, 1, 0);

        // R7: disable forces low, re-enable restarts
        wr_reg(3'h0, 32'h0);
        wr_reg(3'h4, cnt_word(6, 3));
        wr_reg(3'h0, ctl_word(1, 0, 0, 0));
        wait_rise(found);
        check("R7 running before disable", 32'(found), 32'd1);
        wr_reg(3'h0, ctl_word(0, 0, 0, 0));
        check("R7 low right after disable", 32'(pwm_out), 32'd0);
        count_high(12, h);
        check("R7 stays low while disabled", 32'(h), 32'd0);
        wr_reg(3'h0, ctl_word(1, 0, 0, 0));
        measure("R7 re-enable", 6, 3, 0);

        // R8: held update
        wr_reg(3'h0, 32'h0);
        wr_reg(3'h4, cnt_word(5, 2));
        wr_reg(3'h0, ctl_word(1, 0, 0, 0));
        wr_reg(3'h0, ctl_word(1, 1, 0, 0));
        wr_reg(3'h4, cnt_word(8, 6));
        wr_reg(3'h0, ctl_word(1, 1, 0, 1));
        rd_reg(3'h4, v);
        check("R8 held count reads back", v, cnt_word(8, 6));
        measure("R8 old waveform while held", 5, 2, 0);
        measure("R8 old waveform again", 5, 2, 0);
        wr_reg(3'h0, ctl_word(1, 0, 0, 1));
        measure("R8 released together", 8, 6, 1);

        // R9: mid-period update lands at the boundary
        wr_reg(3'h0, 32'h0);
        wr_reg(3'h4, cnt_word(5, 2));
        wr_reg(3'h0, ctl_word(1, 0, 0, 0));
        wait_rise(found);
        check("R9 running", 32'(found), 32'd1);
        wr_reg(3'h4, cnt_word(3, 1));
        seq = {7'd0, pwm_out};
        for (int i = 0; i < 7; i++) begin
            @(negedge clk);
            seq = {seq[6:0], pwm_out};
        end
        check("R9 old period then new", 32'(seq), 32'b1000_1001);

        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end

endmodule